// File: doc/BRIEF.md
# Serial Peripheral Master with Programmable Timing Gaps

This block drives a four-wire serial peripheral bus as the master. A start strobe launches a single frame of 8 to 16 bits to one of four peripherals. The frame is sent most significant bit first, and a word is received at the same time on the input line. The serial clock is a divided copy of the system clock. Its idle level follows the polarity setting, and a phase setting picks the edge that captures input data.

Three programmed waits frame every transfer. The first is a lead-in counted before any chip select drops. The second runs from chip-select assertion to the first serial clock edge. The third is a guard time after the select is released, before the block will accept a new frame. Every wait and the clock half-period are counted in system clock cycles. A setting below its minimum is raised to that minimum. All settings are taken when the start strobe is accepted and are held for the whole frame. When the guard time ends, the block returns to idle. In that same cycle it raises a one-cycle done pulse, and the received word is presented right-aligned.

Top module: `spi_seq_master`

## Requirements
- R1: A `start` seen while idle begins a frame. `busy` is high from the next cycle until the cycle `done` is high. A `start` seen while `busy` is high is ignored.
- R2: At most one bit of `cs_n` is low at any time. The low bit is `cs_n[cs_sel]`, and no select is low while the block is idle.
- R3: The chosen select goes low exactly P cycles after the clock edge that accepted `start`, where P = max(`pre_dly`, 4).
- R4: The first serial clock edge comes exactly L cycles after the select goes low, where L = max(`lead_dly`, 2).
- R5: Consecutive serial clock edges are H cycles apart, where H = max(`half_div`, 2), so the clock period is 2H. A frame of N bits has exactly 2N edges, and the select is released H cycles after the last edge.
- R6: `done` is high exactly G cycles after the select is released, where G = max(`gap_dly`, 6).
- R7: While idle, `sck` equals the `cpol` input sampled on the previous clock edge.
- R8: Bit order is MSB first in both directions. Edges are numbered from 1. With `cpha`=0, odd edges capture `miso` and even edges advance `mosi`. With `cpha`=1, even edges capture and odd edges other than edge 1 advance `mosi`. `mosi` carries the MSB from select assertion onward.
- R9: N is `frame_bits` limited to the range 8..16. `rx_word` holds the received N bits in its low bits, and the bits above are zero.
- R10: `done` lasts exactly one cycle, and `busy` is low in that cycle.
- R11: The word, select index, length, polarity, phase, divider and delays are all taken at `start`. Changing any of them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| tx_word | input | 16 | Word to send; the low N bits are used |
| cs_sel | input | 2 | Index of the peripheral to select |
| frame_bits | input | 5 | Frame length in bits, limited to 8..16 |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Capture edge choice |
| half_div | input | 13 | Serial clock half-period in cycles (min 2) |
| pre_dly | input | 18 | Wait before select assertion (min 4) |
| lead_dly | input | 13 | Select-to-first-edge wait (min 2) |
| gap_dly | input | 13 | Guard time after select release (min 6) |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 4 | Active-low chip selects |
| rx_word | output | 16 | Received word, right-aligned |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |

## Verification
The bench sweeps all four polarity/phase modes against every frame length from 8 to 16. It rotates the select index and uses small, changing delays. A model peripheral checks bit order and edge roles: if a design swaps capture and drive edges, or shifts on edge 1 with phase 1, the received words come out shifted by one bit. Every wait is measured in cycles and compared with arithmetic totals, so an off-by-one in any down-counter shows up as a wrong measured value. Settings below their minimums, lengths outside 8..16, and inputs changed with a second start mid-frame are also tested. A design that clamps wrongly, leaves stale high bits in `rx_word`, or re-reads live inputs would produce the wrong length, select or timing.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_LEAD  = 3'd2,
      ST_SHIFT = 3'd3,
      ST_GAP   = 3'd4
   } spi_seq_state_e;
endpackage

// File: rtl/spi_seq_dcount.sv
// Loadable down-counter that stops at zero.
module spi_seq_dcount #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi_seq_shreg.sv
// Transmit and receive shift registers for variable-length, MSB-first frames.
module spi_seq_shreg #(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LEN_W-1:0]    len,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                shift_en,
   input  logic                capture_en,
   input  logic                miso,
   output logic                mosi,
   output logic [MAX_BITS-1:0] rx_sr
);
   localparam logic [LEN_W-1:0] FULL = LEN_W'(MAX_BITS);

   logic [MAX_BITS-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr <= '0;
         rx_sr <= '0;
      end else if (load) begin
         // left-align so the frame MSB sits at the top bit
         tx_sr <= tx_word << (FULL - len);
         rx_sr <= '0;
      end else begin
         if (shift_en)   tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
         if (capture_en) rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
      end
   end

   assign mosi = tx_sr[MAX_BITS-1];
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
   import spi_seq_pkg::*;
#(
   parameter int MAX_BITS = 16,
   parameter int MIN_BITS = 8,
   parameter int NUM_CS   = 4,
   parameter int HDIV_W   = 13,
   parameter int PRE_W    = 18,
   parameter int LEAD_W   = 13,
   parameter int GAP_W    = 13,
   parameter int MIN_HDIV = 2,
   parameter int MIN_PRE  = 4,
   parameter int MIN_LEAD = 2,
   parameter int MIN_GAP  = 6,
   localparam int CS_W    = $clog2(NUM_CS),
   localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic [CS_W-1:0]     cs_sel,
   input  logic [LEN_W-1:0]    frame_bits,
   input  logic                cpol,
   input  logic                cpha,
   input  logic [HDIV_W-1:0]   half_div,
   input  logic [PRE_W-1:0]    pre_dly,
   input  logic [LEAD_W-1:0]   lead_dly,
   input  logic [GAP_W-1:0]    gap_dly,
   input  logic                miso,
   output logic                sck,
   output logic                mosi,
   output logic [NUM_CS-1:0]   cs_n,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                done,
   output logic                busy
);
   localparam int EDGE_W = LEN_W + 1;
   localparam int CNT_W  = (PRE_W >= LEAD_W && PRE_W >= GAP_W) ? PRE_W :
                           (LEAD_W >= GAP_W) ? LEAD_W : GAP_W;
   localparam logic [LEN_W-1:0]  MIN_LEN_V  = LEN_W'(MIN_BITS);
   localparam logic [LEN_W-1:0]  MAX_LEN_V  = LEN_W'(MAX_BITS);
   localparam logic [HDIV_W-1:0] MIN_HDIV_V = HDIV_W'(MIN_HDIV);
   localparam logic [PRE_W-1:0]  MIN_PRE_V  = PRE_W'(MIN_PRE);
   localparam logic [LEAD_W-1:0] MIN_LEAD_V = LEAD_W'(MIN_LEAD);
   localparam logic [GAP_W-1:0]  MIN_GAP_V  = GAP_W'(MIN_GAP);

   // elaboration-time parameter checks
   if (MIN_BITS < 2 || MIN_BITS > MAX_BITS) begin : g_bad_len
      $error("spi_seq_master: MIN_BITS must be in 2..MAX_BITS");
   end
   if (NUM_CS < 2) begin : g_bad_cs
      $error("spi_seq_master: NUM_CS must be at least 2");
   end
   if (MIN_HDIV < 1 || MIN_PRE < 1 || MIN_LEAD < 1 || MIN_GAP < 1) begin : g_bad_min
      $error("spi_seq_master: delay minimums must be at least 1");
   end
   if (MIN_PRE >= (1 << PRE_W) || MIN_GAP >= (1 << GAP_W) ||
       MIN_LEAD >= (1 << LEAD_W) || MIN_HDIV >= (1 << HDIV_W)) begin : g_bad_w
      $error("spi_seq_master: a minimum does not fit its field");
   end

   spi_seq_state_e state_q, state_d;

   logic [CS_W-1:0]   idx_q;
   logic              cpha_q, cpol_q, tog_q, done_q;
   logic [LEN_W-1:0]  len_q;
   logic [HDIV_W-1:0] hdiv_q;
   logic [LEAD_W-1:0] lead_q;
   logic [GAP_W-1:0]  gap_q;
   logic [EDGE_W-1:0] edge_cnt_q, edge_num, last_edge;
   logic [MAX_BITS-1:0] rx_sr, rx_word_q;

   // settings raised to their minimums at the moment of acceptance
   logic [LEN_W-1:0]  len_eff;
   logic [HDIV_W-1:0] hdiv_eff;
   logic [PRE_W-1:0]  pre_eff;
   logic [LEAD_W-1:0] lead_eff;
   logic [GAP_W-1:0]  gap_eff;

   assign len_eff  = (frame_bits < MIN_LEN_V) ? MIN_LEN_V :
                     (frame_bits > MAX_LEN_V) ? MAX_LEN_V : frame_bits;
   assign hdiv_eff = (half_div < MIN_HDIV_V) ? MIN_HDIV_V : half_div;
   assign pre_eff  = (pre_dly  < MIN_PRE_V)  ? MIN_PRE_V  : pre_dly;
   assign lead_eff = (lead_dly < MIN_LEAD_V) ? MIN_LEAD_V : lead_dly;
   assign gap_eff  = (gap_dly  < MIN_GAP_V)  ? MIN_GAP_V  : gap_dly;

   logic             accept, edge_fire, capture_en, shift_en, leave_shift, done_d;
   logic             ph_load, ph_dec, ph_zero, bd_load, bd_dec, bd_zero;
   logic [CNT_W-1:0] ph_val;

   assign last_edge = {len_q, 1'b0};

   always_comb begin
      state_d     = state_q;
      accept      = 1'b0;
      edge_fire   = 1'b0;
      edge_num    = edge_cnt_q + 1'b1;
      leave_shift = 1'b0;
      done_d      = 1'b0;
      ph_load     = 1'b0;
      ph_val      = '0;
      ph_dec      = 1'b0;
      bd_load     = 1'b0;
      bd_dec      = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start) begin
            accept  = 1'b1;
            state_d = ST_PRE;
            ph_load = 1'b1;
            ph_val  = CNT_W'(pre_eff - 1'b1);
         end
         ST_PRE: if (ph_zero) begin
            state_d = ST_LEAD;
            ph_load = 1'b1;
            ph_val  = CNT_W'(lead_q - 1'b1);
         end else ph_dec = 1'b1;
         ST_LEAD: if (ph_zero) begin
            state_d   = ST_SHIFT;
            edge_fire = 1'b1;
            edge_num  = EDGE_W'(1);
            bd_load   = 1'b1;
         end else ph_dec = 1'b1;
         ST_SHIFT: if (bd_zero) begin
            if (edge_cnt_q == last_edge) begin
               state_d     = ST_GAP;
               leave_shift = 1'b1;
               ph_load     = 1'b1;
               ph_val      = CNT_W'(gap_q - 1'b1);
            end else begin
               edge_fire = 1'b1;
               bd_load   = 1'b1;
            end
         end else bd_dec = 1'b1;
         ST_GAP: if (ph_zero) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
         end else ph_dec = 1'b1;
         default: state_d = ST_IDLE;
      endcase
   end

   // odd edges capture when phase is 0, even edges when phase is 1
   assign capture_en = edge_fire & (edge_num[0] ^ cpha_q);
   assign shift_en   = edge_fire & ~capture_en & (edge_num != EDGE_W'(1));

   spi_seq_dcount #(.W(CNT_W)) u_phase_cnt (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
      .dec(ph_dec), .zero(ph_zero)
   );

   spi_seq_dcount #(.W(HDIV_W)) u_half_cnt (
      .clk(clk), .rst_n(rst_n), .load(bd_load), .load_val(hdiv_q - 1'b1),
      .dec(bd_dec), .zero(bd_zero)
   );

   spi_seq_shreg #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(accept), .len(len_eff), .tx_word(tx_word),
      .shift_en(shift_en), .capture_en(capture_en), .miso(miso),
      .mosi(mosi), .rx_sr(rx_sr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         cpha_q     <= 1'b0;
         cpol_q     <= 1'b0;
         len_q      <= MIN_LEN_V;
         hdiv_q     <= MIN_HDIV_V;
         lead_q     <= MIN_LEAD_V;
         gap_q      <= MIN_GAP_V;
         edge_cnt_q <= '0;
         tog_q      <= 1'b0;
         rx_word_q  <= '0;
         done_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         if (state_q == ST_IDLE) cpol_q <= cpol;
         if (accept) begin
            idx_q      <= cs_sel;
            cpha_q     <= cpha;
            len_q      <= len_eff;
            hdiv_q     <= hdiv_eff;
            lead_q     <= lead_eff;
            gap_q      <= gap_eff;
            edge_cnt_q <= '0;
         end else if (edge_fire) begin
            edge_cnt_q <= edge_num;
         end
         if (edge_fire)   tog_q     <= ~tog_q;
         if (leave_shift) rx_word_q <= rx_sr;
      end
   end

   logic cs_act;
   assign cs_act = (state_q == ST_LEAD) || (state_q == ST_SHIFT);

   for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs
      assign cs_n[gi] = ~(cs_act && (idx_q == CS_W'(gi)));
   end

   assign sck     = cpol_q ^ tog_q;
   assign busy    = (state_q != ST_IDLE);
   assign done    = done_q;
   assign rx_word = rx_word_q;
endmodule

// File: rtl/spi_seq_master_chk.sv
module spi_seq_master_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              cpol,
   input logic              busy,
   input logic              done,
   input logic              sck,
   input logic [NUM_CS-1:0] cs_n
);
   assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (&cs_n));

   assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_sck_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && $past(rst_n)) |-> (sck == $past(cpol)));

   assert_sck_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sck) && busy && $past(busy)) |-> !(&cs_n));
endmodule

bind spi_seq_master spi_seq_master_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .busy(busy),
   .done(done), .sck(sck), .cs_n(cs_n)
);

// File: tb/spi_seq_master_test.sv
module spi_seq_master_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] tx_word = '0;
   logic [1:0]  cs_sel = '0;
   logic [4:0]  frame_bits = 5'd8;
   logic        cpol = 1'b0;
   logic        cpha = 1'b0;
   logic [12:0] half_div = 13'd2;
   logic [17:0] pre_dly = 18'd4;
   logic [12:0] lead_dly = 13'd2;
   logic [12:0] gap_dly = 13'd6;
   logic        miso = 1'b0;
   logic        sck, mosi, done, busy;
   logic [3:0]  cs_n;
   logic [15:0] rx_word;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_seq_master uut (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .cs_sel(cs_sel),
      .frame_bits(frame_bits), .cpol(cpol), .cpha(cpha), .half_div(half_div),
      .pre_dly(pre_dly), .lead_dly(lead_dly), .gap_dly(gap_dly), .miso(miso),
      .sck(sck), .mosi(mosi), .cs_n(cs_n), .rx_word(rx_word), .done(done), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int atleast(input int v, input int m);
      return (v < m) ? m : v;
   endfunction

   // model peripheral: mirrors the edge roles of R8
   task automatic slave(input int idx, input int n, input int ph, input int sw,
                        output int got);
      int sreg;
      sreg = sw;
      got = 0;
      wait (cs_n[idx] == 1'b0);
      miso = sreg[n-1];
      for (int k = 1; k <= 2*n; k++) begin
         @(sck);
         if (((k % 2) == 1) ^ (ph == 1)) got = (got << 1) | int'(mosi);
         else if (k != 1) begin
            sreg = sreg << 1;
            miso = sreg[n-1];
         end
      end
   endtask

   task automatic run_frame(input int idx, input int word, input int fb, input int cp,
                            input int ph, input int h, input int p, input int l,
                            input int g, input int sw, input bit disturb);
      int n, hh, pp, ll, gg, mask, got;
      int c, t_cs, t_e1, t_e2, t_rel, t_done, nedges;
      bit prev_sck, bad_cs;
      n  = (fb < 8) ? 8 : (fb > 16) ? 16 : fb;
      hh = atleast(h, 2); pp = atleast(p, 4); ll = atleast(l, 2); gg = atleast(g, 6);
      mask = (1 << n) - 1;
      @(negedge clk);
      tx_word = word[15:0]; cs_sel = idx[1:0]; frame_bits = fb[4:0];
      cpol = cp[0]; cpha = ph[0]; half_div = h[12:0]; pre_dly = p[17:0];
      lead_dly = l[12:0]; gap_dly = g[12:0];
      start = 1'b1;
      t_cs = -1; t_e1 = -1; t_e2 = -1; t_rel = -1; t_done = -1; nedges = 0;
      bad_cs = 1'b0; got = 0;
      fork
         begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            c = 0;
            check(sck == cp[0], "R7 idle sck", int'(sck), cp);
            check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
            prev_sck = sck;
            while (t_done < 0 && c < 20000) begin
               @(posedge clk);
               c++;
               @(negedge clk);
               if (disturb && c == 2) begin
                  start = 1'b1; cs_sel = ~idx[1:0]; tx_word = ~word[15:0];
                  frame_bits = 5'd9; cpol = ~cp[0]; cpha = ~ph[0];
                  half_div = 13'd5; pre_dly = 18'd9; lead_dly = 13'd7; gap_dly = 13'd8;
               end
               if (disturb && c == 3) start = 1'b0;
               if (cs_n != 4'hF && cs_n != ~(4'b1 << idx)) bad_cs = 1'b1;
               if (t_cs < 0 && cs_n != 4'hF) t_cs = c;
               if (t_cs >= 0 && t_rel < 0 && cs_n == 4'hF) t_rel = c;
               if (sck != prev_sck && t_cs >= 0 && t_rel < 0) begin
                  nedges++;
                  if (t_e1 < 0) t_e1 = c;
                  else if (t_e2 < 0) t_e2 = c;
               end
               prev_sck = sck;
               if (done) begin
                  t_done = c;
                  check(busy == 1'b0, "R10 busy low with done", int'(busy), 0);
               end
            end
         end
         slave(idx, n, ph, sw, got);
      join
      check(!bad_cs, "R2 select pattern", int'(bad_cs), 0);
      check(t_cs == pp, "R3 pre-select delay", t_cs, pp);
      check(t_e1 - t_cs == ll, "R4 select to first edge", t_e1 - t_cs, ll);
      check(t_e2 - t_e1 == hh, "R5 half period", t_e2 - t_e1, hh);
      check(nedges == 2*n, "R5 edge count", nedges, 2*n);
      check(t_rel - t_e1 == 2*n*hh, "R5 release after last edge", t_rel - t_e1, 2*n*hh);
      check(t_done - t_rel == gg, "R6 guard time", t_done - t_rel, gg);
      check(got == (word & mask), "R8 peripheral received", got, word & mask);
      check(int'(rx_word) == (sw & mask), "R9 rx_word aligned", int'(rx_word), sw & mask);
      @(negedge clk);
      check(done == 1'b0, "R10 done one cycle", int'(done), 0);
      if (disturb) begin
         // the ignored start must not have begun a second frame (R1, R11)
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (busy || cs_n != 4'hF) begin
               check(1'b0, "R1 ignored start", int'(busy), 0);
               break;
            end
         end
         check(!busy, "R1 no second frame", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cs_n == 4'hF, "R2 reset selects high", int'(cs_n), 15);
      check(busy == 1'b0 && done == 1'b0, "R1 reset idle", int'(busy), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(sck == 1'b0, "R7 reset sck", int'(sck), 0);

      // sweep: every mode, every length, rotating select and delays
      for (int m = 0; m < 4; m++) begin
         for (int n = 8; n <= 16; n++) begin
            run_frame((m + n) % 4, (16'hA5C3 ^ (n * 16'h1111)) & 16'hFFFF, n,
                      m / 2, m % 2, 2 + (n % 2), 4 + (n % 3), 2 + (m % 2),
                      6 + (n % 2), (16'h3C5A + m * n * 777) & 16'hFFFF, 1'b0);
         end
      end
      // settings below their minimums, length below range (R3 R4 R5 R6 R9)
      run_frame(2, 16'h00B7, 3, 0, 1, 1, 0, 0, 0, 16'hFF4D, 1'b0);
      // length above range with mid-frame changes and a second start (R11)
      run_frame(1, 16'hC0DE, 20, 1, 0, 3, 5, 3, 7, 16'h9E37, 1'b1);
      // longer waits, odd length, disturbed (R11)
      run_frame(3, 16'h5AF0, 11, 1, 1, 9, 300, 37, 41, 16'h0F1E, 1'b1);
      run_frame(0, 16'hFFFF, 16, 0, 0, 2, 4, 2, 6, 16'h0000, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule